// File: doc/BRIEF.md
# Serial Acknowledge Interrupt Priority Chain

This block settles which of several interrupting devices is acknowledged, using a chain of identical stages wired in series. Each stage holds a pending flag that its device sets with a one-cycle request pulse. The OR of all pending flags forms one shared interrupt line to the processor. The processor's acknowledge enters stage 0 and ripples down the chain. A stage with nothing pending passes the acknowledge on to the next stage. A stage with a pending request absorbs the acknowledge and places its own fixed vector on the shared vector bus.

Priority therefore comes from position alone, and stage 0 is the highest. A vector is taken on every clock edge at which the acknowledge is high and a stage is enabled. That edge clears the enabled stage's flag. The acknowledge that leaves the last stage is brought out so that further chains can be cascaded behind this one. The stage count, the vector width and the vector numbering are parameters.

Top module: `irq_daisy_chain`

## Requirements
- R1: `irq_out` is high exactly when at least one pending flag is set. A `dev_req[i]` pulse sets flag i at the next rising edge, so `irq_out` follows one cycle after the pulse.
- R2: While `ack_in` is low, `vec_bus` is 0, `chain_out` is 0 and no pending flag is cleared.
- R3: While `ack_in` is high, the pending stage with the lowest index i drives `vec_bus` to VEC_BASE + i*VEC_STEP, truncated to VEC_W bits. With the defaults (4 stages, base 0x40, step 4) the values are 0x40, 0x44, 0x48 and 0x4C.
- R4: While `ack_in` is high and no flag is pending, `chain_out` is 1 and `vec_bus` is 0. Whenever some stage is enabled, `chain_out` is 0.
- R5: At a rising edge where `ack_in` is high, the enabled stage's flag is cleared. All other flags keep their value.
- R6: At most one stage drives the vector bus in any cycle.
- R7: If a stage's own request pulse coincides with the edge at which that stage is served, the flag stays set. The setting takes priority over the clearing.
- R8: A request that arrives while `ack_in` is high is kept pending. It is served later, in priority order.
- R9: An active-low `rst_n` clears every pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | N_STAGES | One-cycle request pulse per device; bit 0 has the highest priority |
| ack_in | input | 1 | Acknowledge from the processor; enters stage 0 |
| irq_out | output | 1 | Shared interrupt request to the processor |
| vec_bus | output | VEC_W | Vector of the enabled stage, or 0 when no stage is enabled |
| chain_out | output | 1 | Acknowledge leaving the last stage |

## Verification
The assertions check two things on every cycle: that at most one stage is enabled, and that the bus stays quiet without an acknowledge. They also check that each request sets its flag and that each service clears the flag unless a new pulse arrives in the same cycle. Only the bench's scenarios can show that the stage which wins is the lowest-indexed pending one, and that lower-priority requests survive repeated service of higher ones. The same scenarios cover requests that land during an acknowledge and are served later, and the coincident set-and-clear case. A behavioural reference model, built on the pending set and the vector numbering, supplies the expected values for each of these.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  // Vector of stage idx: base + idx*step, truncated by the caller.
  function automatic logic [31:0] stage_vector(input int unsigned base,
                                               input int unsigned step,
                                               input int unsigned idx);
    stage_vector = base + idx * step;
  endfunction
endpackage

// File: rtl/irq_chain_stage.sv
module irq_chain_stage #(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 'h40,
  parameter int unsigned VEC_STEP = 4,
  parameter int unsigned IDX      = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_req,
  input  logic             pri_in,
  output logic             pri_out,
  output logic             pending,
  output logic             vec_en,
  output logic [VEC_W-1:0] vec_out
);
  import irq_chain_pkg::*;

  localparam logic [31:0]      VEC_FULL = stage_vector(VEC_BASE, VEC_STEP, IDX);
  localparam logic [VEC_W-1:0] MY_VEC   = VEC_FULL[VEC_W-1:0];

  logic pend_q;
  logic served;

  // Served: acknowledge reached this stage while it holds a request.
  assign served  = pri_in & pend_q;
  assign pri_out = pri_in & ~pend_q;
  assign vec_en  = served;
  assign vec_out = served ? MY_VEC : '0;
  assign pending = pend_q;

  // A new pulse wins over the clear of the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (dev_req) pend_q <= 1'b1;
    else if (served)  pend_q <= 1'b0;
  end

  // R1 / R7: a pulse always leaves the flag set.
  p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |=> pend_q);

  // R5: service without a new pulse clears the flag.
  p_serve_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (served && !dev_req) |=> !pend_q);

  // R2: no acknowledge at this stage, no request: flag unchanged.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_in && !dev_req) |=> $stable(pend_q));
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned VEC_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_STAGES-1:0]               en,
  input  logic [N_STAGES-1:0][VEC_W-1:0]    vec_in,
  output logic [VEC_W-1:0]                  vec_bus
);
  logic [N_STAGES:0][VEC_W-1:0] acc;

  assign acc[0] = '0;
  for (genvar g = 0; g < N_STAGES; g++) begin : g_or
    assign acc[g+1] = acc[g] | vec_in[g];
  end
  assign vec_bus = acc[N_STAGES];

  // R6: at most one stage drives the shared bus.
  p_single_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en));
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain #(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 'h40,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] dev_req,
  input  logic                ack_in,
  output logic                irq_out,
  output logic [VEC_W-1:0]    vec_bus,
  output logic                chain_out
);
  logic [N_STAGES:0]                 pri;
  logic [N_STAGES-1:0]               pend;
  logic [N_STAGES-1:0]               en;
  logic [N_STAGES-1:0][VEC_W-1:0]    vecs;

  assign pri[0] = ack_in;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    irq_chain_stage #(
      .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .IDX(g)
    ) u_stage (
      .clk(clk), .rst_n(rst_n), .dev_req(dev_req[g]),
      .pri_in(pri[g]), .pri_out(pri[g+1]),
      .pending(pend[g]), .vec_en(en[g]), .vec_out(vecs[g])
    );
  end

  irq_vec_merge #(.N_STAGES(N_STAGES), .VEC_W(VEC_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .en(en), .vec_in(vecs), .vec_bus(vec_bus)
  );

  assign irq_out   = |pend;
  assign chain_out = pri[N_STAGES];

  // R2: without an acknowledge the bus and the chain output stay quiet.
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_in |-> (vec_bus == '0 && !chain_out));

  // R1: the shared line only rises after some device pulsed.
  p_irq_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(|dev_req));

  // R4: a pass-through to the end means no stage is enabled.
  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |-> (en == '0));
endmodule

// File: tb/test_irq_daisy_chain.sv
module test_irq_daisy_chain;
  localparam int N    = 4;
  localparam int VW   = 8;
  localparam int BASE = 'h40;
  localparam int STEP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic          ack_in = 1'b0;
  logic          irq_out;
  logic [VW-1:0] vec_bus;
  logic          chain_out;

  int n_chk = 0;
  int n_bad = 0;
  bit model_pend [N];

  always #4 clk = ~clk;

  irq_daisy_chain #(.N_STAGES(N), .VEC_W(VW), .VEC_BASE(BASE), .VEC_STEP(STEP))
    i_irq_daisy_chain (.clk(clk), .rst_n(rst_n), .dev_req(dev_req), .ack_in(ack_in),
                       .irq_out(irq_out), .vec_bus(vec_bus), .chain_out(chain_out));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare against the model, then advance the model at the edge.
  task automatic step(input logic [N-1:0] req, input logic ack, input string tag);
    int win;
    int exp_vec;
    int any;
    @(negedge clk);
    dev_req = req;
    ack_in  = ack;
    #1;
    win = -1;
    any = 0;
    foreach (model_pend[i]) if (model_pend[i]) begin
      any = 1;
      if (win < 0) win = i;
    end
    exp_vec = (ack && win >= 0) ? ((BASE + win * STEP) % (1 << VW)) : 0;
    check({tag, " R1 irq"}, irq_out, any);
    check({tag, " R3 vec"}, vec_bus, exp_vec);
    check({tag, " R4 chain"}, chain_out, (ack && win < 0) ? 1 : 0);
    @(posedge clk);
    if (ack && win >= 0) model_pend[win] = 0;   // R5
    foreach (model_pend[i]) if (req[i]) model_pend[i] = 1;   // R7: set wins
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    foreach (model_pend[i]) model_pend[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9 irq reset", irq_out, 0);
    check("R9 vec reset", vec_bus, 0);
    @(negedge clk);
    rst_n = 1'b1;

    step('0, 1'b1, "R4 empty ack");
    step(4'b0100, 1'b0, "R1 single req");
    step('0, 1'b0, "R2 held no ack");
    step('0, 1'b0, "R2 held again");
    step('0, 1'b1, "R3 serve stage2");
    step('0, 1'b1, "R4 after serve");
    step(4'b1011, 1'b0, "R1 multi req");
    step('0, 1'b1, "R3 serve stage0");
    step('0, 1'b1, "R3 serve stage1");
    step('0, 1'b0, "R2 pause");
    step('0, 1'b1, "R3 serve stage3");
    step(4'b0010, 1'b0, "R7 setup");
    step(4'b0010, 1'b1, "R7 coincident");
    step('0, 1'b0, "R7 still pending");
    step('0, 1'b1, "R7 serve again");
    step(4'b1000, 1'b1, "R8 req during ack");
    step(4'b0001, 1'b1, "R8 serve stage3");
    step('0, 1'b1, "R8 serve stage0");
    step('0, 1'b1, "R8 drained");

    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] r;
      r = '0;
      for (int b = 0; b < N; b++) if (($urandom % 5) == 0) r[b] = 1'b1;
      step(r, logic'($urandom % 2), "R6 random");
    end
    for (int k = 0; k < 6; k++) step('0, 1'b1, "R5 drain");

    @(negedge clk);
    rst_n = 1'b0;
    foreach (model_pend[i]) model_pend[i] = 0;
    #1;
    check("R9 reset again", irq_out, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule